// File: doc/BRIEF.md
# Transmit Lane Source Selector

This block decides which character each of four transmit lanes hands to the line encoder in every internal character cycle. Each lane character is an 8-bit data byte with a control (K) flag and an idle flag. The block runs on the internal character clock, which is twice the host interface clock. The host side arrives as two samples per lane for each interface-clock period: the rising-edge sample and the falling-edge sample. Each lane output carries a valid flag.

Three sources are supported. In normal mode each lane replays its own two samples, rising-edge sample first. In link-multiplexer mode the host interface is single-edge, so only the rising-edge samples count. The characters of lanes A and B are interleaved onto output lane A, and those of C and D onto output lane C, with the lower-numbered lane first. Output lanes B and D are then unused. In repeater mode each output lane carries the character recovered by the receive lane of the same index, and all host transmit inputs are ignored.

Operation is organised in character pairs. A small state machine has the states SEL_WAIT (after reset, nothing valid), NRM_1ST/NRM_2ND (normal), MUX_1ST/MUX_2ND (interleave) and RPT_1ST/RPT_2ND (repeater). Each *_1ST state always moves to its *_2ND state. SEL_WAIT and every *_2ND state move to RPT_1ST when the repeater input is high, otherwise to MUX_1ST when the multiplexer input is high, otherwise to NRM_1ST. The host samples and the mode are taken only on that pair-boundary transition.

Top module: `tx_lane_selector`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, out_valid, out_data, out_k, out_idle and out_second are all zero.
- R2: In normal mode, for every lane i, the first cycle of a pair outputs that lane's rising-edge sample and the second outputs its falling-edge sample. out_valid is 4'b1111 in both cycles.
- R3: In link-multiplexer mode, output lane 0 carries the rising-edge sample of lane 0 and then that of lane 1, and output lane 2 carries lane 2 and then lane 3. Lanes 1 and 3 have valid, data, K and idle at zero, so out_valid is 4'b0101. Falling-edge samples are not used.
- R4: In repeater mode, each output lane i shows the receive character (rx_data byte i, rx_k bit i) that was present before the clock edge that starts that output cycle. out_idle is 0 and out_valid is 4'b1111.
- R5: In repeater mode the host data, K and idle inputs have no effect on any output.
- R6: When rep_en and lme_en are both high at a pair boundary, repeater behaviour (R4) is selected.
- R7: A host character whose idle flag is set is output with out_idle=1, data 8'h00 and K=0, whatever its data and K inputs hold.
- R8: Mode inputs are sampled only at pair boundaries. out_second is 0 in the first cycle of a pair and 1 in the second, and out_valid stays the same across both cycles of a pair, whatever the mode inputs do in between.
- R9: Host samples are captured at the pair boundary. Changes to the host inputs during the second cycle of a pair do not alter that pair's second character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal character clock (twice the interface clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| lme_en | input | 1 | Link-multiplexer mode request |
| rep_en | input | 1 | Repeater mode request (priority) |
| tx_rise_data | input | 32 | Rising-edge sample bytes, lane i in bits 8i+7..8i |
| tx_rise_k | input | 4 | Rising-edge sample K flags, bit i per lane |
| tx_rise_idle | input | 4 | Rising-edge sample idle flags |
| tx_fall_data | input | 32 | Falling-edge sample bytes |
| tx_fall_k | input | 4 | Falling-edge sample K flags |
| tx_fall_idle | input | 4 | Falling-edge sample idle flags |
| rx_data | input | 32 | Recovered receive bytes per lane |
| rx_k | input | 4 | Recovered receive K flags |
| out_data | output | 32 | Selected data byte per lane |
| out_k | output | 4 | Selected K flag per lane |
| out_idle | output | 4 | Selected idle flag per lane |
| out_valid | output | 4 | Lane carries a character this cycle |
| out_second | output | 1 | Second character of the current pair |

## Verification
A state machine out of step shows up in the very next cycle. out_second fails to alternate, or out_valid changes inside a pair, or the characters of the rising-edge and falling-edge samples appear swapped. A wrongly selected mode gives a different valid pattern (4'b0101 against 4'b1111) in the first cycle of the pair, and host bytes appear where receive bytes were due. A stale or early capture register shows as the wrong byte in the second cycle, because the bench changes the host inputs and inverts the mode inputs in that cycle.

// File: rtl/tx_sel_pkg.sv
package tx_sel_pkg;

    typedef enum logic [2:0] {
        SEL_WAIT = 3'd0,
        NRM_1ST  = 3'd1,
        NRM_2ND  = 3'd2,
        MUX_1ST  = 3'd3,
        MUX_2ND  = 3'd4,
        RPT_1ST  = 3'd5,
        RPT_2ND  = 3'd6
    } sel_state_e;

endpackage

// File: rtl/tx_sel_fsm.sv
module tx_sel_fsm
    import tx_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lme_i,
    input  logic       rep_i,
    output sel_state_e st_o,
    output logic       load_o,
    output logic       second_o
);

    sel_state_e st_q, st_nx, pair_start;

    // Repeater outranks the multiplexer; normal is the fallback.
    always_comb begin
        if (rep_i)      pair_start = RPT_1ST;
        else if (lme_i) pair_start = MUX_1ST;
        else            pair_start = NRM_1ST;
    end

    always_comb begin
        unique case (st_q)
            SEL_WAIT, NRM_2ND, MUX_2ND, RPT_2ND: st_nx = pair_start;
            NRM_1ST:                             st_nx = NRM_2ND;
            MUX_1ST:                             st_nx = MUX_2ND;
            RPT_1ST:                             st_nx = RPT_2ND;
            default:                             st_nx = SEL_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEL_WAIT;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_o     = st_q;
        load_o   = (st_q == SEL_WAIT) || (st_q == NRM_2ND) ||
                   (st_q == MUX_2ND)  || (st_q == RPT_2ND);
        second_o = (st_q == NRM_2ND) || (st_q == MUX_2ND) || (st_q == RPT_2ND);
    end

endmodule

// File: rtl/tx_sel_capture.sv
module tx_sel_capture #(
    parameter int LANES  = 4,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load_i,
    input  logic [LANES*(DATA_W+2)-1:0]    rise_i,
    input  logic [LANES*(DATA_W+2)-1:0]    fall_i,
    input  logic [LANES*(DATA_W+1)-1:0]    rx_i,
    output logic [LANES*(DATA_W+2)-1:0]    rise_q,
    output logic [LANES*(DATA_W+2)-1:0]    fall_q,
    output logic [LANES*(DATA_W+1)-1:0]    rx_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else if (load_i) begin
            rise_q <= rise_i;
            fall_q <= fall_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_i;
    end

endmodule

// File: rtl/tx_sel_lane.sv
module tx_sel_lane
    import tx_sel_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CW    = DATA_W + 2,
    localparam int RW    = DATA_W + 1
) (
    input  sel_state_e        st_i,
    input  logic [CW-1:0]     rise_i,
    input  logic [CW-1:0]     fall_i,
    input  logic [CW-1:0]     mxa_i,
    input  logic [CW-1:0]     mxb_i,
    input  logic              mx_en_i,
    input  logic [RW-1:0]     rx_i,
    output logic [DATA_W-1:0] data_o,
    output logic              k_o,
    output logic              idle_o,
    output logic              valid_o
);

    // Character layout: {idle, k, data}. Idle wipes data and K.
    function automatic logic [CW-1:0] scrub(input logic [CW-1:0] c);
        if (c[CW-1]) return {1'b1, 1'b0, {DATA_W{1'b0}}};
        return c;
    endfunction

    logic [CW-1:0] ch;

    always_comb begin
        ch      = '0;
        valid_o = 1'b0;
        unique case (st_i)
            NRM_1ST: begin ch = scrub(rise_i); valid_o = 1'b1; end
            NRM_2ND: begin ch = scrub(fall_i); valid_o = 1'b1; end
            MUX_1ST: begin ch = mx_en_i ? scrub(mxa_i) : '0; valid_o = mx_en_i; end
            MUX_2ND: begin ch = mx_en_i ? scrub(mxb_i) : '0; valid_o = mx_en_i; end
            RPT_1ST, RPT_2ND: begin ch = {1'b0, rx_i}; valid_o = 1'b1; end
            default: begin ch = '0; valid_o = 1'b0; end
        endcase
    end

    assign idle_o = ch[CW-1];
    assign k_o    = ch[CW-2];
    assign data_o = ch[DATA_W-1:0];

endmodule

// File: rtl/tx_lane_selector.sv
module tx_lane_selector
    import tx_sel_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lme_en,
    input  logic                      rep_en,
    input  logic [LANES*DATA_W-1:0]   tx_rise_data,
    input  logic [LANES-1:0]          tx_rise_k,
    input  logic [LANES-1:0]          tx_rise_idle,
    input  logic [LANES*DATA_W-1:0]   tx_fall_data,
    input  logic [LANES-1:0]          tx_fall_k,
    input  logic [LANES-1:0]          tx_fall_idle,
    input  logic [LANES*DATA_W-1:0]   rx_data,
    input  logic [LANES-1:0]          rx_k,
    output logic [LANES*DATA_W-1:0]   out_data,
    output logic [LANES-1:0]          out_k,
    output logic [LANES-1:0]          out_idle,
    output logic [LANES-1:0]          out_valid,
    output logic                      out_second
);

    localparam int CW = DATA_W + 2;
    localparam int RW = DATA_W + 1;

    sel_state_e st;
    logic       load;

    logic [LANES*CW-1:0] rise_in, fall_in, rise_q, fall_q;
    logic [LANES*RW-1:0] rx_in, rx_q;

    for (genvar i = 0; i < LANES; i++) begin : g_pack
        assign rise_in[i*CW +: CW] = {tx_rise_idle[i], tx_rise_k[i], tx_rise_data[i*DATA_W +: DATA_W]};
        assign fall_in[i*CW +: CW] = {tx_fall_idle[i], tx_fall_k[i], tx_fall_data[i*DATA_W +: DATA_W]};
        assign rx_in[i*RW +: RW]   = {rx_k[i], rx_data[i*DATA_W +: DATA_W]};
    end

    tx_sel_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lme_i    (lme_en),
        .rep_i    (rep_en),
        .st_o     (st),
        .load_o   (load),
        .second_o (out_second)
    );

    tx_sel_capture #(.LANES(LANES), .DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .rise_i (rise_in),
        .fall_i (fall_in),
        .rx_i   (rx_in),
        .rise_q (rise_q),
        .fall_q (fall_q),
        .rx_q   (rx_q)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [CW-1:0] mxa, mxb;
        logic          mx_en;
        if ((i % 2) == 0) begin : g_even
            assign mxa   = rise_q[i*CW +: CW];
            assign mxb   = rise_q[(i+1)*CW +: CW];
            assign mx_en = 1'b1;
        end else begin : g_odd
            assign mxa   = '0;
            assign mxb   = '0;
            assign mx_en = 1'b0;
        end

        tx_sel_lane #(.DATA_W(DATA_W)) u_lane (
            .st_i    (st),
            .rise_i  (rise_q[i*CW +: CW]),
            .fall_i  (fall_q[i*CW +: CW]),
            .mxa_i   (mxa),
            .mxb_i   (mxb),
            .mx_en_i (mx_en),
            .rx_i    (rx_q[i*RW +: RW]),
            .data_o  (out_data[i*DATA_W +: DATA_W]),
            .k_o     (out_k[i]),
            .idle_o  (out_idle[i]),
            .valid_o (out_valid[i])
        );
    end

endmodule

// File: rtl/tx_lane_selector_chk.sv
module tx_lane_selector_chk #(
    parameter int LANES  = 4,
    parameter int DATA_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LANES*DATA_W-1:0] out_data,
    input logic [LANES-1:0]        out_k,
    input logic [LANES-1:0]        out_idle,
    input logic [LANES-1:0]        out_valid,
    input logic                    out_second
);

    function automatic logic idle_lanes_clean(input logic [LANES*DATA_W-1:0] d,
                                              input logic [LANES-1:0] idl);
        for (int i = 0; i < LANES; i++)
            if (idl[i] && d[i*DATA_W +: DATA_W] != '0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic odd_lanes_quiet(input logic [LANES*DATA_W-1:0] d,
                                             input logic [LANES-1:0] kk,
                                             input logic [LANES-1:0] idl,
                                             input logic [LANES-1:0] vld);
        for (int i = 1; i < LANES; i += 2)
            if (vld[i] || kk[i] || idl[i] || d[i*DATA_W +: DATA_W] != '0) return 1'b0;
        return 1'b1;
    endfunction

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (out_valid == '0 && !out_second));

    // R8
    second_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_second |=> !out_second);

    // R8
    pair_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid != '0) && !out_second) |=> out_second);

    // R8
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid != '0) && !out_second) |=> $stable(out_valid));

    // R7
    idle_no_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_idle & out_k) == '0);

    // R7
    idle_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_lanes_clean(out_data, out_idle));

    // R3
    mux_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid != '0) && (out_valid != '1)) |-> odd_lanes_quiet(out_data, out_k, out_idle, out_valid));

endmodule

bind tx_lane_selector tx_lane_selector_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_data   (out_data),
    .out_k      (out_k),
    .out_idle   (out_idle),
    .out_valid  (out_valid),
    .out_second (out_second)
);

// File: tb/tx_lane_selector_tb.sv
module tx_lane_selector_tb;

    localparam int N  = 4;
    localparam int DW = 8;
    localparam int NV = 8;

    // vector: [25] rep, [24] lme, [23:20] rise idle, [19:16] rise k,
    //         [15:12] fall idle, [11:8] fall k, [7:0] seed
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 8'h12},
        {1'b0, 1'b0, 4'h0, 4'h5, 4'h0, 4'hA, 8'h3C},
        {1'b0, 1'b0, 4'h9, 4'hF, 4'h2, 4'h3, 8'h77},
        {1'b0, 1'b1, 4'h0, 4'h6, 4'h0, 4'h0, 8'h5A},
        {1'b0, 1'b1, 4'h6, 4'h3, 4'hF, 4'h0, 8'hA1},
        {1'b1, 1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 8'hC3},
        {1'b1, 1'b1, 4'h0, 4'h5, 4'h5, 4'h0, 8'hE4},
        {1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 4'hF, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lme_en = 1'b0, rep_en = 1'b0;
    logic [N*DW-1:0] tx_rise_data = '0, tx_fall_data = '0, rx_data = '0;
    logic [N-1:0] tx_rise_k = '0, tx_rise_idle = '0, tx_fall_k = '0, tx_fall_idle = '0, rx_k = '0;
    logic [N*DW-1:0] out_data;
    logic [N-1:0] out_k, out_idle, out_valid;
    logic out_second;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tx_lane_selector u_dut (
        .clk(clk), .rst_n(rst_n), .lme_en(lme_en), .rep_en(rep_en),
        .tx_rise_data(tx_rise_data), .tx_rise_k(tx_rise_k), .tx_rise_idle(tx_rise_idle),
        .tx_fall_data(tx_fall_data), .tx_fall_k(tx_fall_k), .tx_fall_idle(tx_fall_idle),
        .rx_data(rx_data), .rx_k(rx_k),
        .out_data(out_data), .out_k(out_k), .out_idle(out_idle),
        .out_valid(out_valid), .out_second(out_second)
    );

    function automatic logic [7:0] rise_byte(input logic [7:0] s, input int j);
        return s ^ 8'(8'h11 * j);
    endfunction
    function automatic logic [7:0] fall_byte(input logic [7:0] s, input int j);
        return ~s + 8'(j);
    endfunction
    function automatic logic [7:0] rx_byte(input logic [7:0] s, input int slot, input int j);
        return s + (slot == 0 ? 8'h40 : 8'h80) + 8'(16 * j);
    endfunction

    // {valid, idle, k, data} expected from the requirements
    function automatic logic [10:0] expect_lane(input logic [25:0] v, input int slot, input int i);
        logic [9:0] c;
        int src;
        if (v[25]) begin
            return {1'b1, 1'b0, (slot == 0 ? v[16 + i] : v[8 + i]), rx_byte(v[7:0], slot, i)};
        end
        if (v[24]) begin
            if (i % 2 == 1) return '0;
            src = i + slot;
            c = {v[20 + src], v[16 + src], rise_byte(v[7:0], src)};
        end else if (slot == 0) begin
            c = {v[20 + i], v[16 + i], rise_byte(v[7:0], i)};
        end else begin
            c = {v[12 + i], v[8 + i], fall_byte(v[7:0], i)};
        end
        if (c[9]) c = {1'b1, 1'b0, 8'h00};
        return {1'b1, c};
    endfunction

    function automatic string tag_of(input logic [25:0] v, input int slot);
        string t;
        if (v[25] && v[24]) t = "R6";
        else if (v[25])     t = "R4 R5";
        else if (v[24])     t = "R3";
        else                t = "R2";
        if ((v[23:20] | v[15:12]) != 0) t = {t, " R7"};
        if (slot == 1) t = {t, " R8 R9"};
        return t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_host(input logic [25:0] v);
        rep_en = v[25];
        lme_en = v[24];
        tx_rise_idle = v[23:20];
        tx_rise_k = v[19:16];
        tx_fall_idle = v[15:12];
        tx_fall_k = v[11:8];
        for (int j = 0; j < N; j++) begin
            tx_rise_data[j*DW +: DW] = rise_byte(v[7:0], j);
            tx_fall_data[j*DW +: DW] = fall_byte(v[7:0], j);
            rx_data[j*DW +: DW] = rx_byte(v[7:0], 0, j);
        end
        rx_k = v[19:16];
    endtask

    task automatic check_slot(input logic [25:0] v, input int slot);
        string t;
        t = tag_of(v, slot);
        check({t, " second flag"}, {31'b0, out_second}, slot);
        for (int i = 0; i < N; i++)
            check({t, $sformatf(" lane %0d", i)},
                  {21'b0, out_valid[i], out_idle[i], out_k[i], out_data[i*DW +: DW]},
                  {21'b0, expect_lane(v, slot, i)});
    endtask

    // Called at a negedge with the vector already driven.
    task automatic run_pair(input logic [25:0] v);
        @(negedge clk);
        check_slot(v, 0);
        // disturb host inputs and mode in the second cycle
        tx_rise_data = ~tx_rise_data;
        tx_fall_data = ~tx_fall_data;
        tx_rise_k = ~tx_rise_k;
        tx_fall_k = ~tx_fall_k;
        tx_rise_idle = ~tx_rise_idle;
        tx_fall_idle = ~tx_fall_idle;
        rep_en = ~rep_en;
        lme_en = ~lme_en;
        for (int j = 0; j < N; j++) rx_data[j*DW +: DW] = rx_byte(v[7:0], 1, j);
        rx_k = v[11:8];
        @(negedge clk);
        check_slot(v, 1);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        drive_host(VEC[2]);
        repeat (3) @(negedge clk);
        // R1: reset state with busy inputs
        check("R1 valid in reset", {28'b0, out_valid}, 32'h0);
        check("R1 data in reset", out_data, 32'h0);
        check("R1 second in reset", {31'b0, out_second}, 32'h0);
        check("R1 flags in reset", {24'b0, out_k, out_idle}, 32'h0);

        // table walk; pairs stay aligned since each vector takes two cycles
        drive_host(VEC[0]);
        rst_n = 1'b1;
        for (int n = 0; n < NV; n++) begin
            if (n > 0) drive_host(VEC[n]);
            run_pair(VEC[n]);
        end

        // R1: asynchronous reset in the middle of a pair
        drive_host(VEC[3]);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 valid after async reset", {28'b0, out_valid}, 32'h0);
        check("R1 second after async reset", {31'b0, out_second}, 32'h0);
        @(negedge clk);
        // R6 via restart straight into repeater+multiplexer request
        drive_host(VEC[6]);
        rst_n = 1'b1;
        run_pair(VEC[6]);
        drive_host(VEC[4]);
        run_pair(VEC[4]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule